// File: doc/BRIEF.md
# Wash Program Sequencer

This block is a clocked controller that steps a washer through one fixed program. The steps are first fill, wash, first drain, second fill, rinse and final drain, after which it returns to idle. Each step lasts a set number of active clock cycles, and those lengths are parameters. A count-down timer inside the block is reloaded at every step change and flags the end of the step when it reaches zero.

Three actuator outputs come out of the block: motor, inlet valve and drain valve. A three-bit step code is also brought out so the program can be observed. A start pulse from idle begins the program. An open lid or a held pause button suspends the program. While it is suspended, all actuators are off and the remaining time of the current step is frozen. When the lid is closed and pause is released, the program carries on from the same point.

Top module: `wash_seq`

## Requirements
- R1: While reset is high, and in the clock cycle after any reset edge, the step code is 0 (idle) and motor, inlet and drain are all 0.
- R2: In idle, a start sampled high at a clock edge while lid_closed is 1 and pause is 0 moves the step code to 1 (first fill) with inlet on after that edge. A start sampled while the lid is open or pause is high leaves the block in idle.
- R3: The step codes follow the order 1 → 2 → 3 → 4 → 5 → 6 → 0, and no other change occurs. Code 1 is first fill, 2 wash, 3 first drain, 4 second fill, 5 rinse, 6 final drain. While not suspended, inlet is the only output on in steps 1 and 4, motor is the only one in steps 2 and 5, and drain is the only one in steps 3 and 6.
- R4: Each step lasts exactly its parameter length in active cycles. Fill steps use FILL_LEN, wash uses WASH_LEN, both drain steps use DRAIN_LEN and rinse uses RINSE_LEN.
- R5: Start has no effect while a program is running. Holding it high leaves the step order and every step length unchanged, and step 1 is entered only from idle.
- R6: At most one of motor, inlet and drain is 1 at any time.
- R7: Motor is 0 in every cycle in which lid_closed is 0.
- R8: Outside idle, lid_closed = 0 or pause = 1 suspends the program. All three outputs are 0 in the same cycle, and the step code and the remaining step time hold. Once the program resumes, the step's outputs return and the step completes its remaining active cycles.
- R9: After the final drain the block is in idle with all outputs off, and a new start is accepted as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start button, sampled at the clock edge |
| lid_closed | input | 1 | 1 when the lid is shut, 0 when open |
| pause | input | 1 | Hold high to suspend the program |
| motor | output | 1 | Drum motor enable |
| inlet | output | 1 | Water inlet valve open |
| drain | output | 1 | Water drain valve open |
| phase | output | 3 | Current step code (0 idle, 1..6 as in R3) |

## Verification
If the step register is wrong, the step code and the actuator pattern show it in the cycle after the bad edge. A skipped or repeated step is therefore visible at once. A timer that reloads with the wrong value, or keeps counting during a suspension, changes how many active cycles a step lasts. That error appears only when the step ends, so the bench counts active cycles per step over whole programs, some run with suspensions and some with start held high. A suspension gate that fails shows up as an actuator on during the very cycle the lid opens.

// File: rtl/wash_seq_pkg.sv
package wash_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_FILL1  = 3'd1,
      PH_WASH   = 3'd2,
      PH_DRAIN1 = 3'd3,
      PH_FILL2  = 3'd4,
      PH_RINSE  = 3'd5,
      PH_DRAIN2 = 3'd6
   } phase_t;

   localparam int ACT_MOTOR = 0;
   localparam int ACT_INLET = 1;
   localparam int ACT_DRAIN = 2;
   localparam int N_ACT     = 3;

   // Actuator pattern that belongs to a step
   function automatic logic [N_ACT-1:0] act_for(phase_t p);
      logic [N_ACT-1:0] a;
      a = '0;
      case (p)
         PH_FILL1, PH_FILL2:   a[ACT_INLET] = 1'b1;
         PH_WASH, PH_RINSE:    a[ACT_MOTOR] = 1'b1;
         PH_DRAIN1, PH_DRAIN2: a[ACT_DRAIN] = 1'b1;
         default:              a = '0;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/wash_seq_timer.sv
module wash_seq_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic          en,
   input  logic [CW-1:0] val,
   output logic          done
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (load) cnt_q <= val;
      else if (en)   cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/wash_seq_fsm.sv
module wash_seq_fsm
   import wash_seq_pkg::*;
#(
   parameter int CW        = 4,
   parameter int FILL_LEN  = 5,
   parameter int WASH_LEN  = 8,
   parameter int DRAIN_LEN = 4,
   parameter int RINSE_LEN = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             run_ok,
   input  logic             done,
   output phase_t           phase_q,
   output logic [N_ACT-1:0] act_q,
   output logic             tmr_load,
   output logic             tmr_en,
   output logic [CW-1:0]    tmr_val
);

   phase_t nxt;
   logic   adv;

   function automatic int step_len(phase_t p);
      case (p)
         PH_FILL1, PH_FILL2:   return FILL_LEN;
         PH_WASH:              return WASH_LEN;
         PH_DRAIN1, PH_DRAIN2: return DRAIN_LEN;
         PH_RINSE:             return RINSE_LEN;
         default:              return 1;
      endcase
   endfunction

   always_comb begin
      adv = 1'b0;
      nxt = phase_q;
      case (phase_q)
         PH_IDLE: begin
            if (start && run_ok) begin
               adv = 1'b1;
               nxt = PH_FILL1;
            end
         end
         PH_DRAIN2: begin
            if (run_ok && done) begin
               adv = 1'b1;
               nxt = PH_IDLE;
            end
         end
         default: begin
            if (run_ok && done) begin
               adv = 1'b1;
               nxt = phase_t'(phase_q + 3'd1);
            end
         end
      endcase
   end

   assign tmr_load = adv && (nxt != PH_IDLE);
   assign tmr_val  = CW'(step_len(nxt) - 1);
   assign tmr_en   = (phase_q != PH_IDLE) && run_ok && !done;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         act_q   <= '0;
      end else if (adv) begin
         phase_q <= nxt;
         act_q   <= act_for(nxt);
      end
   end

endmodule

// File: rtl/wash_seq.sv
module wash_seq
   import wash_seq_pkg::*;
#(
   parameter int FILL_LEN  = 5,
   parameter int WASH_LEN  = 8,
   parameter int DRAIN_LEN = 4,
   parameter int RINSE_LEN = 6
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic       lid_closed,
   input  logic       pause,
   output logic       motor,
   output logic       inlet,
   output logic       drain,
   output logic [2:0] phase
);

   localparam int MAX_FW  = (FILL_LEN > WASH_LEN) ? FILL_LEN : WASH_LEN;
   localparam int MAX_DR  = (DRAIN_LEN > RINSE_LEN) ? DRAIN_LEN : RINSE_LEN;
   localparam int MAX_LEN = (MAX_FW > MAX_DR) ? MAX_FW : MAX_DR;
   localparam int CW      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

   if (FILL_LEN < 1 || WASH_LEN < 1 || DRAIN_LEN < 1 || RINSE_LEN < 1) begin : g_bad_len
      $error("wash_seq: every step length must be at least 1");
   end

   logic             run_ok;
   logic             done;
   logic             tmr_load;
   logic             tmr_en;
   logic [CW-1:0]    tmr_val;
   phase_t           phase_q;
   logic [N_ACT-1:0] act_q;
   logic [N_ACT-1:0] act_out;

   assign run_ok = lid_closed && !pause;

   wash_seq_fsm #(
      .CW(CW), .FILL_LEN(FILL_LEN), .WASH_LEN(WASH_LEN),
      .DRAIN_LEN(DRAIN_LEN), .RINSE_LEN(RINSE_LEN)
   ) u_fsm (
      .clk(clk), .rst(rst), .start(start), .run_ok(run_ok), .done(done),
      .phase_q(phase_q), .act_q(act_q), .tmr_load(tmr_load),
      .tmr_en(tmr_en), .tmr_val(tmr_val)
   );

   wash_seq_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst(rst), .load(tmr_load), .en(tmr_en),
      .val(tmr_val), .done(done)
   );

   // Suspension gate on each actuator copy
   for (genvar g = 0; g < N_ACT; g++) begin : g_gate
      assign act_out[g] = act_q[g] && run_ok;
   end

   assign motor = act_out[ACT_MOTOR];
   assign inlet = act_out[ACT_INLET];
   assign drain = act_out[ACT_DRAIN];
   assign phase = phase_q;

endmodule

// File: rtl/wash_seq_chk.sv
module wash_seq_chk (
   input logic       clk,
   input logic       rst,
   input logic       start,
   input logic       lid_closed,
   input logic       pause,
   input logic       motor,
   input logic       inlet,
   input logic       drain,
   input logic [2:0] phase
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      (phase == 3'd0) |-> (!motor && !inlet && !drain)); // R1

   AST_STEP_ORDER: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && phase != $past(phase)) |->
         (phase == (($past(phase) == 3'd6) ? 3'd0 : $past(phase) + 3'd1))); // R3

   AST_FILL_ENTRY: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && phase == 3'd1 && $past(phase) != 3'd1) |->
         ($past(phase) == 3'd0 && $past(start))); // R5

   AST_ONE_ACTUATOR: assert property (@(posedge clk) disable iff (rst)
      $onehot0({motor, inlet, drain})); // R6

   AST_LID_MOTOR: assert property (@(posedge clk) disable iff (rst)
      !lid_closed |-> !motor); // R7

   AST_SUSP_OFF: assert property (@(posedge clk) disable iff (rst)
      (phase != 3'd0 && (!lid_closed || pause)) |-> (!motor && !inlet && !drain)); // R8

   AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (phase != 3'd0 && (!lid_closed || pause)) |=> $stable(phase)); // R8

endmodule

bind wash_seq wash_seq_chk u_chk (
   .clk(clk), .rst(rst), .start(start), .lid_closed(lid_closed), .pause(pause),
   .motor(motor), .inlet(inlet), .drain(drain), .phase(phase)
);

// File: tb/sim_wash_seq.sv
module sim_wash_seq;

   localparam int LF = 3;
   localparam int LW = 6;
   localparam int LD = 2;
   localparam int LR = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       lid_closed = 1'b1;
   logic       pause = 1'b0;
   logic       motor, inlet, drain;
   logic [2:0] phase;

   int n_chk  = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   wash_seq #(.FILL_LEN(LF), .WASH_LEN(LW), .DRAIN_LEN(LD), .RINSE_LEN(LR)) u0 (
      .clk(clk), .rst(rst), .start(start), .lid_closed(lid_closed), .pause(pause),
      .motor(motor), .inlet(inlet), .drain(drain), .phase(phase)
   );

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int plen(int p);
      case (p)
         1, 4:    return LF;
         2:       return LW;
         3, 6:    return LD;
         5:       return LR;
         default: return 0;
      endcase
   endfunction

   // {motor, inlet, drain}
   function automatic int pat(int p, bit ok);
      if (!ok) return 0;
      case (p)
         1, 4:    return 3'b010;
         2, 5:    return 3'b100;
         3, 6:    return 3'b001;
         default: return 0;
      endcase
   endfunction

   function automatic int outs();
      return int'({motor, inlet, drain});
   endfunction

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1; start = 1'b0; lid_closed = 1'b1; pause = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check(phase == 3'd0, "R1 reset step", phase, 0);
      check(outs() == 0, "R1 reset outputs", outs(), 0);
      rst = 1'b0;
   endtask

   task automatic t_idle_ignore();
      @(negedge clk);
      lid_closed = 1'b0; start = 1'b1;
      @(negedge clk); #1;
      check(phase == 3'd0, "R2 start with lid open", phase, 0);
      lid_closed = 1'b1; pause = 1'b1;
      @(negedge clk); #1;
      check(phase == 3'd0, "R2 start while paused", phase, 0);
      pause = 1'b0; start = 1'b0;
      @(negedge clk); #1;
      check(phase == 3'd0 && outs() == 0, "R2 idle after ignored starts", outs(), 0);
   endtask

   task automatic do_start(bit hold);
      @(negedge clk);
      start = 1'b1; lid_closed = 1'b1; pause = 1'b0;
      @(negedge clk);
      if (!hold) start = 1'b0;
      #1;
      check(phase == 3'd1, "R2 start enters fill", phase, 1);
      check(outs() == 3'b010, "R2 inlet on after start", outs(), 3'b010);
   endtask

   // Walks a whole program; optional suspension in step sp at in-step index sat for sn samples
   task automatic run_program(bit hold, int sp, int sat, int sn, bit use_pause);
      int cnt[7];
      int prev  = 1;
      int idx   = 1;
      int guard = 0;
      int cur;
      bit ok;
      bit susp;
      for (int p = 0; p < 7; p++) cnt[p] = 0;
      cnt[1] = 1;
      while (1) begin
         @(negedge clk);
         start      = hold && (prev >= 1) && (prev <= 4);
         susp       = (prev == sp) && (idx >= sat) && (idx < sat + sn);
         lid_closed = !(susp && !use_pause);
         pause      = susp && use_pause;
         #1;
         cur = int'(phase);
         ok  = lid_closed && !pause;
         if (cur != prev) begin
            check(cur == ((prev == 6) ? 0 : prev + 1), "R3 step order", cur,
                  (prev == 6) ? 0 : prev + 1);
            prev = cur;
            idx  = 0;
         end
         if (cur == 0) break;
         if (ok)
            check(outs() == pat(cur, 1'b1), "R3 step outputs", outs(), pat(cur, 1'b1));
         else
            check(outs() == 0, "R8 outputs off while suspended", outs(), 0);
         if (!lid_closed) check(motor == 1'b0, "R7 motor with lid open", motor, 0);
         check($countones({motor, inlet, drain}) <= 1, "R6 single actuator",
               $countones({motor, inlet, drain}), 1);
         if (ok) cnt[cur]++;
         idx++;
         guard++;
         if (guard > 500) begin
            check(1'b0, "R4 program did not end", guard, 0);
            break;
         end
      end
      start = 1'b0; lid_closed = 1'b1; pause = 1'b0;
      for (int p = 1; p < 7; p++)
         check(cnt[p] == plen(p), hold ? "R5 step length with start held" :
               (sn > 0 ? "R8 step length across suspension" : "R4 step length"),
               cnt[p], plen(p));
      check(outs() == 0, "R9 idle outputs after final drain", outs(), 0);
   endtask

   task automatic t_reset_mid();
      do_start(1'b0);
      repeat (LF + 2) @(negedge clk);
      rst = 1'b1;
      @(negedge clk); #1;
      check(phase == 3'd0, "R1 reset during program step", phase, 0);
      check(outs() == 0, "R1 reset during program outputs", outs(), 0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk); #1;
      check(phase == 3'd0, "R1 idle after reset release", phase, 0);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      t_reset();
      t_idle_ignore();
      do_start(1'b0);
      run_program(1'b0, 0, 0, 0, 1'b0);           // R4 plain program
      do_start(1'b1);
      run_program(1'b1, 0, 0, 0, 1'b0);           // R5 start held high
      do_start(1'b0);
      run_program(1'b0, 2, 2, 3, 1'b0);           // R7 lid opened in wash
      do_start(1'b0);
      run_program(1'b0, 5, 1, 4, 1'b1);           // R8 pause in rinse
      do_start(1'b0);                             // R9 restart accepted
      run_program(1'b0, 1, 1, 2, 1'b0);           // R8 lid opened in fill
      t_reset_mid();
      finish_run();
   end

endmodule